// File: doc/BRIEF.md
# Sleep and Wake Power Controller

This block sequences power-down for a small 8-bit processor core. A one-cycle sleep strobe from the instruction decoder drops the core clock enable. The same strobe restarts the watchdog count, sets the time-out flag and clears the power-down flag. While the core is dark, only the watchdog counter keeps running on the free-running clock.

The core is woken by one of three sources: a watchdog overflow, a request from the port wake logic, or the external active-low master reset. The port request and the external reset are asynchronous and pass through synchronizer chains first. On wake, the block raises the clock enable again and pulses a request that loads the program counter with the top program address, the same vector used after reset. It also reports which source caused the wake.

If the watchdog overflows while the core is running, the block pulses a reset output and does not treat it as a wake. When software turns the watchdog off, only the port request or the external reset can end power-down.

Top module: `sw_power_ctrl`

## Requirements
- R1: After power-on reset, core_clk_en=1, flag_to=1, flag_pd=1, wake_cause=2'b00, and pc_top_req=0 and wdt_rst=0.
- R2: A sleep_cmd sampled high while awake makes core_clk_en 0 after that edge. The same edge sets flag_to=1, flag_pd=0 and wake_cause=2'b00, and restarts the watchdog count at zero.
- R3: The watchdog counts clock edges while wdt_en=1. With the watchdog enabled, the core wakes exactly WDT_TERM+1 edges after the sleep edge with wake_cause=2'b01, and every watchdog overflow clears flag_to.
- R4: A port_wake request seen through SYNC_STAGES flops wakes the core with wake_cause=2'b10, SYNC_STAGES+1 edges after it is first sampled.
- R5: ext_rst_n held low wakes the core with wake_cause=2'b11 and the same latency as port_wake.
- R6: When several sources are present at the same edge, the cause priority is external reset (2'b11), then watchdog (2'b01), then port (2'b10).
- R7: core_clk_en rises on the edge after the synchronized wake event. pc_top_req is high for exactly that first enabled cycle.
- R8: wake_cause holds its value until the next accepted sleep command. A port_wake request while awake has no effect: it raises no pc_top_req and leaves wake_cause unchanged.
- R9: With wdt_en=0 the watchdog never ends power-down, however long the sleep lasts.
- R10: A watchdog overflow while awake gives a one-cycle wdt_rst pulse. core_clk_en stays 1, no pc_top_req is raised, wake_cause is kept and flag_to is cleared.
- R11: sleep_cmd while asleep is ignored. It does not restart the watchdog count, so the watchdog wake time is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_cmd | input | 1 | Sleep strobe from the decoder |
| wdt_en | input | 1 | Watchdog enable |
| port_wake | input | 1 | Asynchronous wake request from the port wake logic |
| ext_rst_n | input | 1 | External master reset, active low, asynchronous |
| core_clk_en | output | 1 | Core clock enable |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |
| wake_cause | output | 2 | 01 watchdog, 10 port, 11 external reset, 00 none |
| pc_top_req | output | 1 | One-cycle request to load the top program address |
| wdt_rst | output | 1 | One-cycle reset pulse on overflow while awake |

## Verification
The hardest state to reach is a watchdog overflow and a synchronized external reset arriving at the same edge. That is the only way to exercise the cause priority between those two sources, and it needs exact cycle counting. The bench puts the core to sleep with the watchdog enabled and waits a computed number of cycles. It then asserts the external reset exactly SYNC_STAGES+1 edges before the known overflow edge. A sleep strobe issued mid-sleep is checked in the same cycle-exact way, by confirming that the watchdog wake edge does not move.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } pwr_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_WDT  = 2'b01,
        CAUSE_PORT = 2'b10,
        CAUSE_EXT  = 2'b11
    } wake_cause_e;

    typedef struct packed {
        pwr_state_e  state;
        logic        clk_en;
        logic        to;
        logic        pd;
        wake_cause_e cause;
        logic        pc_req;
        logic        wdt_rst;
    } pwr_regs_t;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sw_wdt.sv
module sw_wdt #(
    parameter int unsigned TERM = 1023
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic ovf
);

    localparam int unsigned W = (TERM < 1) ? 1 : $clog2(TERM + 1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q + W'(1);
        ovf   = en && !clr && (cnt_q == W'(TERM));
        if (clr || !en)            cnt_d = '0;
        else if (cnt_q == W'(TERM)) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: count never passes the terminal value
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(TERM))
        else $error("watchdog count beyond terminal");

    // R9: disabled watchdog idles at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0))
        else $error("disabled watchdog not idle");

endmodule

// File: rtl/sw_power_ctrl.sv
module sw_power_ctrl
    import sw_pkg::*;
#(
    parameter int unsigned WDT_TERM    = 1023,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_cmd,
    input  logic       wdt_en,
    input  logic       port_wake,
    input  logic       ext_rst_n,
    output logic       core_clk_en,
    output logic       flag_to,
    output logic       flag_pd,
    output logic [1:0] wake_cause,
    output logic       pc_top_req,
    output logic       wdt_rst
);

    localparam int unsigned NSRC     = 2;
    localparam logic [NSRC-1:0] SYNC_RST = 2'b01;   // [0] ext reset idles high, [1] port idles low

    localparam pwr_regs_t REGS_RST = '{
        state:   ST_AWAKE,
        clk_en:  1'b1,
        to:      1'b1,
        pd:      1'b1,
        cause:   CAUSE_NONE,
        pc_req:  1'b0,
        wdt_rst: 1'b0
    };

    logic [NSRC-1:0] raw_in;
    logic [NSRC-1:0] sync_out;
    logic            sleep_go;
    logic            wdt_ovf;
    logic            wake_ext;
    logic            wake_port;
    pwr_regs_t       r_d;
    pwr_regs_t       r_q;

    assign raw_in = {port_wake, ext_rst_n};

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_sync
        sw_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(SYNC_RST[gi])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_in[gi]),
            .q    (sync_out[gi])
        );
    end

    assign wake_ext  = !sync_out[0];
    assign wake_port = sync_out[1];
    assign sleep_go  = (r_q.state == ST_AWAKE) && sleep_cmd;

    sw_wdt #(
        .TERM(WDT_TERM)
    ) u_wdt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wdt_en),
        .clr  (sleep_go),
        .ovf  (wdt_ovf)
    );

    always_comb begin
        r_d         = r_q;
        r_d.pc_req  = 1'b0;
        r_d.wdt_rst = 1'b0;
        if (wdt_ovf) r_d.to = 1'b0;
        case (r_q.state)
            ST_AWAKE: begin
                if (sleep_go) begin
                    r_d.state  = ST_ASLEEP;
                    r_d.clk_en = 1'b0;
                    r_d.to     = 1'b1;
                    r_d.pd     = 1'b0;
                    r_d.cause  = CAUSE_NONE;
                end else if (wdt_ovf) begin
                    r_d.wdt_rst = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake_ext || wdt_ovf || wake_port) begin
                    r_d.state  = ST_AWAKE;
                    r_d.clk_en = 1'b1;
                    r_d.pc_req = 1'b1;
                    if (wake_ext)     r_d.cause = CAUSE_EXT;
                    else if (wdt_ovf) r_d.cause = CAUSE_WDT;
                    else              r_d.cause = CAUSE_PORT;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign core_clk_en = r_q.clk_en;
    assign flag_to     = r_q.to;
    assign flag_pd     = r_q.pd;
    assign wake_cause  = r_q.cause;
    assign pc_top_req  = r_q.pc_req;
    assign wdt_rst     = r_q.wdt_rst;

    // R2: accepted sleep gates the clock and writes the flags
    a_r2_sleep_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && sleep_cmd) |=> (!core_clk_en && flag_to && !flag_pd))
        else $error("sleep did not gate clock or set flags");

    // R7: restart request is a single cycle
    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_top_req |=> !pc_top_req)
        else $error("restart request longer than one cycle");

    // R7: clock enable only returns together with the restart request
    a_r7_req_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> pc_top_req)
        else $error("clock enabled without restart request");

    // R8: cause changes only on a wake or on a sleep clear
    a_r8_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wake_cause) |-> (pc_top_req || wake_cause == 2'b00))
        else $error("wake cause changed outside wake or sleep");

    // R10: awake overflow is a reset pulse, not a wake
    a_r10_awake_rst: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (core_clk_en && !pc_top_req && !flag_to))
        else $error("awake overflow misbehaved");

endmodule

// File: tb/sw_power_ctrl_tb.sv
`timescale 1ns/1ps
module sw_power_ctrl_tb;

    localparam int TERM = 20;
    localparam int SYNC = 2;
    localparam int NV   = 6;
    // [7] wdt_en [6] port [5] ext [4:3] expected cause [2] expected flag_to
    localparam logic [7:0] VEC [NV] = '{
        8'b100_01_0_00,
        8'b010_10_1_00,
        8'b001_11_1_00,
        8'b110_10_1_00,
        8'b011_11_1_00,
        8'b101_11_1_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       wdt_en = 1'b0;
    logic       port_wake = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       core_clk_en;
    logic       flag_to;
    logic       flag_pd;
    logic [1:0] wake_cause;
    logic       pc_top_req;
    logic       wdt_rst;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sw_power_ctrl #(
        .WDT_TERM   (TERM),
        .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_cmd  (sleep_cmd),
        .wdt_en     (wdt_en),
        .port_wake  (port_wake),
        .ext_rst_n  (ext_rst_n),
        .core_clk_en(core_clk_en),
        .flag_to    (flag_to),
        .flag_pd    (flag_pd),
        .wake_cause (wake_cause),
        .pc_top_req (pc_top_req),
        .wdt_rst    (wdt_rst)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep();
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
    endtask

    task automatic check_asleep();
        chk(!core_clk_en, "R2", "clk_en after sleep", core_clk_en, 0);
        chk(flag_to && !flag_pd && wake_cause == 2'b00, "R2", "to/pd/cause after sleep",
            {flag_to, flag_pd, wake_cause}, 4'b1000);
    endtask

    task automatic wait_dark(input int n, input string req);
        logic ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_clk_en || pc_top_req) ok = 1'b0;
        end
        chk(ok, req, "core stays dark", core_clk_en, 0);
    endtask

    initial begin
        #(4 * 5000);
        n_fail++;
        $display("FAIL watchdog: run hung, got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        chk(core_clk_en && flag_to && flag_pd, "R1", "clk_en/to/pd",
            {core_clk_en, flag_to, flag_pd}, 3'b111);
        chk(wake_cause == 2'b00 && !pc_top_req && !wdt_rst, "R1", "cause/req/rst",
            {wake_cause, pc_top_req, wdt_rst}, 0);
        step(1);

        // table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic       use_sync;
            int         lat;
            wdt_en = VEC[v][7];
            step(4);
            go_sleep();
            check_asleep();
            port_wake = VEC[v][6];
            ext_rst_n = !VEC[v][5];
            use_sync  = VEC[v][6] | VEC[v][5];
            lat       = use_sync ? SYNC + 1 : TERM + 1;
            wait_dark(lat - 1, "R7");
            step(1);
            chk(core_clk_en && pc_top_req, "R7", "wake edge enable/request",
                {core_clk_en, pc_top_req}, 2'b11);
            chk(wake_cause == VEC[v][4:3], "R3 R4 R5 R6", "wake cause",
                wake_cause, VEC[v][4:3]);
            chk(flag_to == VEC[v][2], "R3", "flag_to after wake", flag_to, VEC[v][2]);
            step(1);
            chk(!pc_top_req && core_clk_en, "R7", "request drops after one cycle",
                pc_top_req, 0);
            port_wake = 1'b0;
            ext_rst_n = 1'b1;
        end

        // R8: port request while awake has no effect
        begin
            logic ok = 1'b1;
            wdt_en    = 1'b0;
            port_wake = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (pc_top_req || wake_cause != 2'b11 || !core_clk_en) ok = 1'b0;
            end
            port_wake = 1'b0;
            chk(ok, "R8", "awake port request ignored, cause held", wake_cause, 3);
        end

        // R9: disabled watchdog never wakes
        step(4);
        go_sleep();
        wait_dark(3 * TERM, "R9");
        port_wake = 1'b1;
        step(SYNC + 1);
        chk(core_clk_en && wake_cause == 2'b10, "R9", "port exit after long sleep",
            wake_cause, 2);
        port_wake = 1'b0;

        // R3 exact watchdog wake, then R10 awake overflow
        wdt_en = 1'b1;
        step(4);
        go_sleep();
        wait_dark(TERM, "R3");
        step(1);
        chk(core_clk_en && wake_cause == 2'b01 && !flag_to, "R3", "watchdog wake",
            {core_clk_en, wake_cause, flag_to}, 4'b1010);
        step(TERM);
        chk(!wdt_rst, "R10", "no reset pulse before overflow", wdt_rst, 0);
        step(1);
        chk(wdt_rst && core_clk_en && !pc_top_req, "R10", "awake overflow pulse",
            {wdt_rst, core_clk_en, pc_top_req}, 3'b110);
        chk(wake_cause == 2'b01 && !flag_to, "R10", "cause kept, to cleared",
            {wake_cause, flag_to}, 3'b010);
        step(1);
        chk(!wdt_rst, "R10", "reset pulse one cycle", wdt_rst, 0);

        // R11: sleep strobe while asleep does not restart the count
        step(4);
        go_sleep();
        step(4);
        sleep_cmd = 1'b1;
        step(1);
        sleep_cmd = 1'b0;
        wait_dark(TERM - 5, "R11");
        step(1);
        chk(core_clk_en && wake_cause == 2'b01, "R11", "wake time unchanged",
            {core_clk_en, wake_cause}, 3'b101);

        // R6: watchdog overflow and external reset at the same edge
        step(4);
        go_sleep();
        step(TERM - 2);
        ext_rst_n = 1'b0;
        step(SYNC);
        chk(!core_clk_en, "R6", "still asleep before joint edge", core_clk_en, 0);
        step(1);
        chk(core_clk_en && wake_cause == 2'b11 && !flag_to, "R6", "external beats watchdog",
            {core_clk_en, wake_cause, flag_to}, 4'b1110);
        ext_rst_n = 1'b1;
        step(4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule